// File: doc/BRIEF.md
# Half-Memory Partial-Product Table

This block is the partial-product store for one address group of a multiplier-free adaptive filter built on distributed arithmetic. A group of R input taps forms an R-bit address from one bit-plane of the delayed samples. The full table would need 2^R signed words. Here only 2^(R-1) words are kept. An address and its bitwise complement hold nearly opposite values, so each complementary pair of addresses shares one stored word.

The top address bit picks which member of the pair is meant. When it is clear, the low R-1 bits index the table directly. When it is set, the low bits are complemented to form the index. Negation is then applied to the word read out and to the value that is added in. Both negators saturate, and so does the accumulate. The surrounding filter issues one read and one update per bit-plane, so B of each per sample. The shift-add of the filter output and the error scaling stay outside this block.

Reads are registered. A read request presents the selected word, after any negation, on the output at the next clock edge, together with a valid flag. The value seen is the content before any update that commits on the same edge.

Top module: `hm_pp_table`

## Requirements
- R1: The table holds 2^(ADDR_W-1) words, indexed only by the low ADDR_W-1 address bits. An address with its top bit set selects the word whose index is the bitwise complement of its low bits. With ADDR_W=3, address 3'b111 selects index 0 and address 3'b110 selects index 1.
- R2: A read (`rd_en`=1) with the top address bit 0 returns the selected word unchanged on `rd_data` after the next rising edge, with `rd_valid`=1 in that cycle.
- R3: A read with the top address bit 1 returns the two's-complement negation of the selected word.
- R4: An update (`upd_en`=1) with the top address bit 0 adds `upd_val` to the selected word at the rising edge.
- R5: An update with the top address bit 1 adds the negation of `upd_val` to the selected word.
- R6: Negating the most negative code (-2^(DATA_W-1)) gives the most positive code (2^(DATA_W-1)-1). This holds on both the read path and the update path.
- R7: The accumulate saturates: a sum above the most positive code stores the most positive code, and a sum below the most negative code stores the most negative code.
- R8: When a read and an update select the same word in the same cycle, the read returns the value held before that update.
- R9: Synchronous active-high reset clears every word to 0 and drives `rd_data` to 0 and `rd_valid` to 0.
- R10: In a cycle with `rd_en`=0, `rd_data` keeps its value and `rd_valid` is 0 after the edge. In a cycle with `upd_en`=0, no word changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read request for this cycle |
| rd_addr | input | ADDR_W | Read address; top bit selects the complement form |
| upd_en | input | 1 | Update request for this cycle |
| upd_addr | input | ADDR_W | Update address; top bit selects the complement form |
| upd_val | input | DATA_W | Signed value to accumulate |
| rd_data | output | DATA_W | Registered signed partial product |
| rd_valid | output | 1 | High for the cycle after an accepted read |

## Verification
The bench targets aliasing first: it writes through a complemented address and reads through the plain one, and the reverse. A design that dropped the low-bit inversion would then touch the wrong word, and one that skipped a negator would return a value with the wrong sign. It pushes the most negative code through both negators and drives the accumulate past each rail. A wrap-around instead of saturation shows up there as a sign flip. It also reads and updates the same word in one cycle, where a write-first store would return the new sum instead of the old one. Finally it resets mid-run and reads back, which exposes any word left uncleared.

// File: rtl/hm_pp_pkg.sv
package hm_pp_pkg;
  // Default geometry: 3-bit group address, 16-bit partial products.
  localparam int DEF_ADDR_W = 3;
  localparam int DEF_DATA_W = 16;

  // Role of a folded address: plain half or complement half of the table.
  typedef enum logic {
    HALF_PLAIN = 1'b0,
    HALF_FLIP  = 1'b1
  } half_e;
endpackage

// File: rtl/hm_addr_fold.sv
module hm_addr_fold
  import hm_pp_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  localparam int IDX_W = ADDR_W - 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output half_e             half
);
  // The top bit selects the complement half; complement the low bits for it.
  always_comb begin
    half = half_e'(addr[ADDR_W-1]);
    idx  = (half == HALF_FLIP) ? ~addr[IDX_W-1:0] : addr[IDX_W-1:0];
  end

  always_comb begin
    // p_fold_inverse_r1: folding keeps the complementary pairing intact
    p_fold_inverse_r1: assert ((idx ^ addr[IDX_W-1:0]) ==
                               {IDX_W{addr[ADDR_W-1]}});
  end
endmodule

// File: rtl/hm_sat_neg.sv
module hm_sat_neg
  import hm_pp_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W
) (
  input  half_e                     half,
  input  logic signed [DATA_W-1:0]  din,
  output logic signed [DATA_W-1:0]  dout
);
  localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic signed [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};

  always_comb begin
    if (half == HALF_PLAIN)  dout = din;
    else if (din == MIN_V)   dout = MAX_V;
    else                     dout = -din;
  end

  always_comb begin
    // p_neg_exact_r3: away from the rail, the flipped path is an exact negation
    p_neg_exact_r3: assert (half == HALF_PLAIN || din == MIN_V ||
                            (dout + din) == '0);
    // p_neg_rail_r6: the flipped path never produces the most negative code
    p_neg_rail_r6: assert (half == HALF_PLAIN || dout != MIN_V);
  end
endmodule

// File: rtl/hm_pp_store.sv
module hm_pp_store
  import hm_pp_pkg::*;
#(
  parameter int IDX_W  = DEF_ADDR_W - 1,
  parameter int DATA_W = DEF_DATA_W,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic signed [DATA_W-1:0]  wr_delta,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic signed [DATA_W-1:0]  rd_word
);
  localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic signed [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};

  logic signed [DATA_W-1:0] mem [DEPTH];
  logic signed [DATA_W:0]   wide_sum;
  logic signed [DATA_W-1:0] sat_sum;

  // One extra bit catches overflow; clamp toward the rail of the true sign.
  always_comb begin
    wide_sum = {mem[wr_idx][DATA_W-1], mem[wr_idx]} + {wr_delta[DATA_W-1], wr_delta};
    if (wide_sum[DATA_W] != wide_sum[DATA_W-1])
      sat_sum = wide_sum[DATA_W] ? MIN_V : MAX_V;
    else
      sat_sum = wide_sum[DATA_W-1:0];
  end

  assign rd_word = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= sat_sum;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_word_chk
    // p_untouched_r10: a word not addressed by an update keeps its value
    p_untouched_r10: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_idx == IDX_W'(g)) |=> $stable(mem[g]));
    // p_sat_up_r7: adding a non-negative delta never lowers a word
    p_sat_up_r7: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_idx == IDX_W'(g) && !wr_delta[DATA_W-1]) |=>
        ($signed(mem[g]) >= $signed($past(mem[g]))));
    // p_sat_down_r7: adding a negative delta never raises a word
    p_sat_down_r7: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_idx == IDX_W'(g) && wr_delta[DATA_W-1]) |=>
        ($signed(mem[g]) <= $signed($past(mem[g]))));
  end
endmodule

// File: rtl/hm_pp_table.sv
module hm_pp_table
  import hm_pp_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int DATA_W = DEF_DATA_W,
  localparam int IDX_W = ADDR_W - 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         rd_addr,
  input  logic                      upd_en,
  input  logic [ADDR_W-1:0]         upd_addr,
  input  logic signed [DATA_W-1:0]  upd_val,
  output logic signed [DATA_W-1:0]  rd_data,
  output logic                      rd_valid
);
  logic [IDX_W-1:0]         rd_idx, up_idx;
  half_e                    rd_half, up_half;
  logic signed [DATA_W-1:0] raw_word, rd_next, up_delta;

  hm_addr_fold #(.ADDR_W(ADDR_W)) u_rd_fold (
    .addr(rd_addr), .idx(rd_idx), .half(rd_half));

  hm_addr_fold #(.ADDR_W(ADDR_W)) u_up_fold (
    .addr(upd_addr), .idx(up_idx), .half(up_half));

  // Write-side negator: the complement half accumulates the negated value.
  hm_sat_neg #(.DATA_W(DATA_W)) u_up_neg (
    .half(up_half), .din(upd_val), .dout(up_delta));

  hm_pp_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(upd_en), .wr_idx(up_idx), .wr_delta(up_delta),
    .rd_idx(rd_idx), .rd_word(raw_word));

  // Read-side negator on the pre-update word, then the output register.
  hm_sat_neg #(.DATA_W(DATA_W)) u_rd_neg (
    .half(rd_half), .din(raw_word), .dout(rd_next));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_next;
    end
  end

  // p_valid_follow_r2: an accepted read raises the valid flag one edge later
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  // p_idle_hold_r10: with no read, the output holds and valid stays low
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (!rd_valid && $stable(rd_data)));
  // p_reset_clear_r9: reset empties the output register
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !rd_valid));
endmodule

// File: tb/hm_pp_table_tb.sv
module hm_pp_table_tb;
  localparam int AW = 3;
  localparam int DW = 16;
  localparam int NV = 13;

  typedef struct packed {
    logic                  rd;
    logic [AW-1:0]         ra;
    logic                  up;
    logic [AW-1:0]         ua;
    logic signed [DW-1:0]  uv;
    logic                  chk;
    logic signed [DW-1:0]  ex;
  } vec_t;

  // Each row is one cycle. Words start at 0; the running contents are in the comments.
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'b000, 1'b1, 3'b000,  16'sd100,    1'b1, 16'sd0},      // w0=100, read sees old 0 (R8)
    '{1'b1, 3'b000, 1'b1, 3'b111,  16'sd30,     1'b1, 16'sd100},    // read 100 (R2); w0=70 via flip (R1)
    '{1'b1, 3'b111, 1'b0, 3'b000,  16'sd0,      1'b1, -16'sd70},    // flipped read of w0 (R3)
    '{1'b1, 3'b010, 1'b1, 3'b101, -16'sd25,     1'b1, 16'sd0},      // w2=+25 via flip (R5), old 0 (R8)
    '{1'b1, 3'b010, 1'b0, 3'b000,  16'sd0,      1'b1, 16'sd25},     // plain read of w2 (R5)
    '{1'b0, 3'b000, 1'b1, 3'b001,  16'sd32767,  1'b0, 16'sd0},      // w1=32767 (R4)
    '{1'b1, 3'b110, 1'b1, 3'b001,  16'sd5,      1'b1, -16'sd32767}, // w1 clamps high (R7); flip read
    '{1'b1, 3'b001, 1'b1, 3'b010, -16'sd32768,  1'b1, 16'sd32767},  // w1 held at max (R7); w2=-32743
    '{1'b0, 3'b000, 1'b1, 3'b010, -16'sd32768,  1'b0, 16'sd0},      // w2 clamps low (R7)
    '{1'b1, 3'b101, 1'b0, 3'b000,  16'sd0,      1'b1, 16'sd32767},  // read-side rail negation (R6)
    '{1'b1, 3'b011, 1'b1, 3'b100, -16'sd32768,  1'b1, 16'sd0},      // write-side rail: w3=32767 (R6)
    '{1'b1, 3'b011, 1'b0, 3'b000,  16'sd0,      1'b1, 16'sd32767},  // w3 readback (R6)
    '{1'b1, 3'b000, 1'b0, 3'b000,  16'sd0,      1'b1, 16'sd70}      // w0 untouched (R10)
  };

  string vtag [NV] = '{"R8", "R2", "R3", "R5", "R5", "R4", "R7",
                       "R7", "R7", "R6", "R6", "R6", "R10"};

  logic                 clk = 1'b0;
  logic                 rst;
  logic                 rd_en, upd_en;
  logic [AW-1:0]        rd_addr, upd_addr;
  logic signed [DW-1:0] upd_val;
  logic signed [DW-1:0] rd_data;
  logic                 rd_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hm_pp_table #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .upd_en(upd_en), .upd_addr(upd_addr), .upd_val(upd_val),
    .rd_data(rd_data), .rd_valid(rd_valid));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    rd_en = 1'b0; upd_en = 1'b0; rd_addr = '0; upd_addr = '0; upd_val = '0;
  endtask

  initial begin
    idle();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #2;
    check("R9 rd_data after reset", int'(rd_data), 0);
    check("R9 rd_valid after reset", int'(rd_valid), 0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rd_en = VECS[i].rd; rd_addr = VECS[i].ra;
      upd_en = VECS[i].up; upd_addr = VECS[i].ua; upd_val = VECS[i].uv;
      @(posedge clk);
      #2;
      if (VECS[i].chk) check(vtag[i], int'(rd_data), int'(VECS[i].ex));
      check({vtag[i], " R2 rd_valid"}, int'(rd_valid), int'(VECS[i].rd));
    end

    // R10: no read and no update, while the update inputs still carry live values.
    @(negedge clk);
    idle();
    upd_addr = 3'b000; upd_val = 16'sd999;
    @(posedge clk);
    #2;
    check("R10 rd_data held", int'(rd_data), 70);
    check("R10 rd_valid low", int'(rd_valid), 0);
    @(negedge clk);
    idle();
    rd_en = 1'b1; rd_addr = 3'b000;
    @(posedge clk);
    #2;
    check("R10 w0 unchanged without upd_en", int'(rd_data), 70);

    // R9: a mid-run reset clears every word.
    @(negedge clk);
    idle();
    rst = 1'b1;
    @(posedge clk);
    #2;
    check("R9 rd_data on reset", int'(rd_data), 0);
    check("R9 rd_valid on reset", int'(rd_valid), 0);
    @(negedge clk);
    rst = 1'b0;
    rd_en = 1'b1; rd_addr = 3'b011;
    @(posedge clk);
    #2;
    check("R9 w3 cleared", int'(rd_data), 0);
    @(negedge clk);
    rd_addr = 3'b110;
    @(posedge clk);
    #2;
    check("R9 w1 cleared", int'(rd_data), 0);
    @(negedge clk);
    idle();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule